// File: doc/BRIEF.md
# Test Access Port State Sequencer

This block is the sequencing core of a boundary-scan and debug test port. It owns the sixteen-state controller that a serial test host steers with a single mode-select line sampled on each rising edge of the test clock. It has no other control input. From the current state it produces one-hot strobes for the instruction path and the data path: capture, shift and update for each. It also raises a reset indication while the port logic is held in its reset state.

A half-cycle-delayed enable for the serial output driver is registered on the falling edge of the test clock. It is high only while a shift state is active. The instruction register, the data registers, the opcode decoder and the output multiplexer all sit outside this block and are steered by these strobes.

An active-low asynchronous reset pin can force the controller into its reset state. A parameter removes this pin's effect for ports that have no reset wire; in that case the mode-select line alone returns the controller to reset. The current state is also presented as a 4-bit code so that neighbouring logic and test equipment can observe the sequence.

Top module: `tap_sequencer`

## Requirements
- R1: While `trstN` is low, `tapState` is 0 (reset) and `tdoEnable` is 0, without waiting for a clock edge and regardless of `tms`. After `trstN` rises, the first rising edge with `tms`=0 moves to idle (code 1).
- R2: `tapState` uses these codes. 0 = reset, 1 = idle. For the data branch: 2 = select, 3 = capture, 4 = shift, 5 = exit1, 6 = pause, 7 = exit2, 8 = update. For the instruction branch: 9 = select, 10 = capture, 11 = shift, 12 = exit1, 13 = pause, 14 = exit2, 15 = update. The state changes only on the rising edge of `tck`, and the next state depends only on the current state and `tms`.
- R3: From any state, five consecutive rising edges with `tms`=1 leave the controller in reset (code 0). Reset stays put while `tms`=1 and goes to idle on `tms`=0.
- R4: From reset, the `tms` sequence 0,1,1,0,0 reaches instruction shift (code 11). From there, `tms` 1 then 1 reaches instruction update (code 15).
- R5: A shift state stays put while `tms`=0, and it moves to its exit1 state on `tms`=1.
- R6: In each branch, capture goes to shift on 0 and to exit1 on 1. Exit1 goes to pause on 0 and to update on 1. Pause stays on 0 and goes to exit2 on 1. Exit2 goes back to shift on 0 and to update on 1.
- R7: In the `tapState` codes of R2, exactly one of the outputs `tapReset`, `captureIr`, `shiftIr`, `updateIr`, `captureDr`, `shiftDr` and `updateDr` is high in states 0, 10, 11, 15, 3, 4 and 8 respectively, and none is high in any other state.
- R8: `tdoEnable` changes only on the falling edge of `tck`. There it takes the value 1 when the state is 4 or 11, and 0 otherwise, so it lags a state change by half a clock.
- R9: Idle stays on 0 and goes to data select on 1. Data select goes to capture on 0 and to instruction select on 1. Instruction select goes to capture on 0 and to reset on 1. Both update states go to idle on 0 and to data select on 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; state advances on its rising edge |
| tms | input | 1 | Mode select steering the state transitions |
| trstN | input | 1 | Active-low asynchronous reset of the controller |
| tapState | output | 4 | Current state code (encoding in R2) |
| tapReset | output | 1 | High while in the reset state |
| captureIr | output | 1 | Instruction-path capture strobe |
| shiftIr | output | 1 | Instruction-path shift strobe |
| updateIr | output | 1 | Instruction-path update strobe |
| captureDr | output | 1 | Data-path capture strobe |
| shiftDr | output | 1 | Data-path shift strobe |
| updateDr | output | 1 | Data-path update strobe |
| tdoEnable | output | 1 | Serial output driver enable, registered on falling edge |

## Verification
One long `tms` stream visits all sixteen states and takes both arcs out of every state. It separates swapped branch targets, for example a pause that leaves on the wrong level or an exit2 that re-enters update instead of shift. The five-ones recovery is tried from every prefix of that stream, so a state that needs more than five edges to reach reset is caught. A four-ones run shows that reset is not reached early. Separate patterns assert the reset pin in mid-cycle, and they look at the output enable on both sides of the falling edge, which tells a falling-edge register apart from a rising-edge or combinational one.

// File: rtl/tapseq_pkg.sv
package tapseq_pkg;

  localparam int STATE_W = 4;
  localparam int STROBE_N = 7;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET      = 4'd0,
    ST_IDLE       = 4'd1,
    ST_DR_SELECT  = 4'd2,
    ST_DR_CAPTURE = 4'd3,
    ST_DR_SHIFT   = 4'd4,
    ST_DR_EXIT1   = 4'd5,
    ST_DR_PAUSE   = 4'd6,
    ST_DR_EXIT2   = 4'd7,
    ST_DR_UPDATE  = 4'd8,
    ST_IR_SELECT  = 4'd9,
    ST_IR_CAPTURE = 4'd10,
    ST_IR_SHIFT   = 4'd11,
    ST_IR_EXIT1   = 4'd12,
    ST_IR_PAUSE   = 4'd13,
    ST_IR_EXIT2   = 4'd14,
    ST_IR_UPDATE  = 4'd15
  } tapState_e;

  // Strobe bundle passed from control to the output stage.
  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobes_t;

  // Successor of a state for one sampled mode-select level.
  function automatic tapState_e stepState(input tapState_e cur, input logic tmsBit);
    tapState_e nxt;
    case (cur)
      ST_RESET:      nxt = tmsBit ? ST_RESET     : ST_IDLE;
      ST_IDLE:       nxt = tmsBit ? ST_DR_SELECT : ST_IDLE;
      ST_DR_SELECT:  nxt = tmsBit ? ST_IR_SELECT : ST_DR_CAPTURE;
      ST_DR_CAPTURE: nxt = tmsBit ? ST_DR_EXIT1  : ST_DR_SHIFT;
      ST_DR_SHIFT:   nxt = tmsBit ? ST_DR_EXIT1  : ST_DR_SHIFT;
      ST_DR_EXIT1:   nxt = tmsBit ? ST_DR_UPDATE : ST_DR_PAUSE;
      ST_DR_PAUSE:   nxt = tmsBit ? ST_DR_EXIT2  : ST_DR_PAUSE;
      ST_DR_EXIT2:   nxt = tmsBit ? ST_DR_UPDATE : ST_DR_SHIFT;
      ST_DR_UPDATE:  nxt = tmsBit ? ST_DR_SELECT : ST_IDLE;
      ST_IR_SELECT:  nxt = tmsBit ? ST_RESET     : ST_IR_CAPTURE;
      ST_IR_CAPTURE: nxt = tmsBit ? ST_IR_EXIT1  : ST_IR_SHIFT;
      ST_IR_SHIFT:   nxt = tmsBit ? ST_IR_EXIT1  : ST_IR_SHIFT;
      ST_IR_EXIT1:   nxt = tmsBit ? ST_IR_UPDATE : ST_IR_PAUSE;
      ST_IR_PAUSE:   nxt = tmsBit ? ST_IR_EXIT2  : ST_IR_PAUSE;
      ST_IR_EXIT2:   nxt = tmsBit ? ST_IR_UPDATE : ST_IR_SHIFT;
      ST_IR_UPDATE:  nxt = tmsBit ? ST_DR_SELECT : ST_IDLE;
      default:       nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tapseq_pkg::*;
#(
  parameter int RECOVER_EDGES = 5
) (
  input  logic      tck,
  input  logic      rstN,
  input  logic      tms,
  output tapState_e state
);

  localparam int RUN_W = $clog2(RECOVER_EDGES + 1);

  tapState_e stateNext;

  always_comb stateNext = stepState(state, tms);

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  // Run of consecutive high mode-select samples, for the recovery check.
  logic [RUN_W-1:0] onesRun;
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                             onesRun <= '0;
    else if (!tms)                         onesRun <= '0;
    else if (onesRun != RUN_W'(RECOVER_EDGES)) onesRun <= onesRun + 1'b1;
  end

  p_ones_recover_r3: assert property (@(posedge tck) disable iff (!rstN)
    onesRun == RUN_W'(RECOVER_EDGES) |-> state == ST_RESET);

  p_reset_sticky_r3: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_RESET && tms) |=> state == ST_RESET);

  p_shift_hold_r5: assert property (@(posedge tck) disable iff (!rstN)
    ((state == ST_DR_SHIFT || state == ST_IR_SHIFT) && !tms) |=> $stable(state));

  p_pause_leave_r6: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_IR_PAUSE && tms) |=> state == ST_IR_EXIT2);

  p_update_exit_r9: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_DR_UPDATE || state == ST_IR_UPDATE)
      |=> (state == ST_IDLE || state == ST_DR_SELECT));

endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tapseq_pkg::*;
(
  input  tapState_e   state,
  output tapStrobes_t strobes
);

  // The two scan branches share a layout; a generate loop builds both.
  localparam int BRANCH_N = 2;

  logic [BRANCH_N-1:0] capHit, shHit, updHit;

  for (genvar b = 0; b < BRANCH_N; b++) begin : g_branch
    localparam tapState_e CAP = (b == 0) ? ST_DR_CAPTURE : ST_IR_CAPTURE;
    localparam tapState_e SHF = (b == 0) ? ST_DR_SHIFT   : ST_IR_SHIFT;
    localparam tapState_e UPD = (b == 0) ? ST_DR_UPDATE  : ST_IR_UPDATE;
    assign capHit[b] = (state == CAP);
    assign shHit[b]  = (state == SHF);
    assign updHit[b] = (state == UPD);
  end

  always_comb begin
    strobes.inReset   = (state == ST_RESET);
    strobes.captureDr = capHit[0];
    strobes.shiftDr   = shHit[0];
    strobes.updateDr  = updHit[0];
    strobes.captureIr = capHit[1];
    strobes.shiftIr   = shHit[1];
    strobes.updateIr  = updHit[1];
  end

endmodule

// File: rtl/tap_outstage.sv
module tap_outstage
  import tapseq_pkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  tapStrobes_t strobes,
  output logic        tapReset,
  output logic        captureIr,
  output logic        shiftIr,
  output logic        updateIr,
  output logic        captureDr,
  output logic        shiftDr,
  output logic        updateDr,
  output logic        tdoEnable
);

  assign tapReset  = strobes.inReset;
  assign captureIr = strobes.captureIr;
  assign shiftIr   = strobes.shiftIr;
  assign updateIr  = strobes.updateIr;
  assign captureDr = strobes.captureDr;
  assign shiftDr   = strobes.shiftDr;
  assign updateDr  = strobes.updateDr;

  logic inShift;
  assign inShift = strobes.shiftIr | strobes.shiftDr;

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) tdoEnable <= 1'b0;
    else       tdoEnable <= inShift;
  end

  p_strobe_excl_r7: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0({tapReset, captureIr, shiftIr, updateIr, captureDr, shiftDr, updateDr}));

  p_oe_match_r8: assert property (@(posedge tck) disable iff (!rstN)
    tdoEnable == inShift);

endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
  import tapseq_pkg::*;
#(
  parameter bit HAS_TRST      = 1'b1,
  parameter int RECOVER_EDGES = 5
) (
  input  logic               tck,
  input  logic               tms,
  input  logic               trstN,
  output logic [STATE_W-1:0] tapState,
  output logic               tapReset,
  output logic               captureIr,
  output logic               shiftIr,
  output logic               updateIr,
  output logic               captureDr,
  output logic               shiftDr,
  output logic               updateDr,
  output logic               tdoEnable
);

  logic        rstN;
  tapState_e   state;
  tapStrobes_t strobes;

  if (HAS_TRST) begin : g_pin_reset
    assign rstN = trstN;
  end else begin : g_tms_reset_only
    assign rstN = 1'b1;
  end

  tap_fsm #(.RECOVER_EDGES(RECOVER_EDGES)) u_fsm (
    .tck   (tck),
    .rstN  (rstN),
    .tms   (tms),
    .state (state)
  );

  tap_decode u_decode (
    .state   (state),
    .strobes (strobes)
  );

  tap_outstage u_out (
    .tck       (tck),
    .rstN      (rstN),
    .strobes   (strobes),
    .tapReset  (tapReset),
    .captureIr (captureIr),
    .shiftIr   (shiftIr),
    .updateIr  (updateIr),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .tdoEnable (tdoEnable)
  );

  assign tapState = state;

endmodule

// File: tb/tap_sequencer_tb.sv
`timescale 1ns/1ps
module tap_sequencer_tb;

  logic       tck = 1'b0;
  logic       tms = 1'b1;
  logic       trstN = 1'b0;
  logic [3:0] tapState;
  logic       tapReset, captureIr, shiftIr, updateIr;
  logic       captureDr, shiftDr, updateDr, tdoEnable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 tck = ~tck;

  tap_sequencer u_dut (
    .tck(tck), .tms(tms), .trstN(trstN), .tapState(tapState),
    .tapReset(tapReset), .captureIr(captureIr), .shiftIr(shiftIr),
    .updateIr(updateIr), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdoEnable(tdoEnable)
  );

  // {tms, expected state after the edge}, starting from reset.
  localparam int NV = 57;
  localparam logic [4:0] VEC [NV] = '{
    {1'b1,4'd0},  {1'b0,4'd1},  {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},
    {1'b0,4'd4},  {1'b0,4'd4},  {1'b1,4'd5},  {1'b0,4'd6},  {1'b0,4'd6},
    {1'b1,4'd7},  {1'b0,4'd4},  {1'b1,4'd5},  {1'b1,4'd8},  {1'b1,4'd2},
    {1'b1,4'd9},  {1'b0,4'd10}, {1'b1,4'd12}, {1'b0,4'd13}, {1'b1,4'd14},
    {1'b1,4'd15}, {1'b0,4'd1},  {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10},
    {1'b0,4'd11}, {1'b0,4'd11}, {1'b1,4'd12}, {1'b1,4'd15}, {1'b1,4'd2},
    {1'b0,4'd3},  {1'b1,4'd5},  {1'b1,4'd8},  {1'b0,4'd1},  {1'b1,4'd2},
    {1'b1,4'd9},  {1'b1,4'd0},
    {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},  {1'b1,4'd5},  {1'b0,4'd6},
    {1'b1,4'd7},  {1'b1,4'd8},  {1'b0,4'd1},
    {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10}, {1'b0,4'd11}, {1'b1,4'd12},
    {1'b0,4'd13}, {1'b0,4'd13}, {1'b1,4'd14}, {1'b0,4'd11}, {1'b1,4'd12},
    {1'b1,4'd15}, {1'b0,4'd1}
  };

  function automatic logic [6:0] expStrobes(input logic [3:0] s);
    return {s == 4'd0, s == 4'd10, s == 4'd11, s == 4'd15,
            s == 4'd3, s == 4'd4, s == 4'd8};
  endfunction

  function automatic logic [6:0] gotStrobes();
    return {tapReset, captureIr, shiftIr, updateIr, captureDr, shiftDr, updateDr};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at posedge+1; sets tms, returns at the next posedge+1.
  task automatic tick(input logic t);
    tms = t;
    @(posedge tck);
    #1;
  endtask

  task automatic pinReset();
    trstN = 1'b0;
    tms   = 1'b1;
    @(posedge tck);
    #1;
    trstN = 1'b1;
  endtask

  initial begin
    #1;
    pinReset();
    // R1 / R7 / R8: reset state
    check(tapState == 4'd0, "R1 reset state", tapState, 0);
    check(gotStrobes() == expStrobes(4'd0), "R7 strobes in reset", gotStrobes(), expStrobes(4'd0));
    check(tdoEnable == 1'b0, "R8 enable in reset", tdoEnable, 0);

    // Table walk: R2, R5, R6, R9 transitions; R7 strobes; R8 enable after falling edge
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][4]);
      check(tapState == VEC[i][3:0], $sformatf("R2 R6 R9 step %0d", i), tapState, VEC[i][3:0]);
      check(gotStrobes() == expStrobes(VEC[i][3:0]), $sformatf("R7 step %0d", i),
            gotStrobes(), expStrobes(VEC[i][3:0]));
      #5;
      check(tdoEnable == (VEC[i][3:0] == 4'd4 || VEC[i][3:0] == 4'd11),
            $sformatf("R8 step %0d", i), tdoEnable,
            (VEC[i][3:0] == 4'd4 || VEC[i][3:0] == 4'd11));
      @(posedge tck);
      #1;
      tms = 1'b1;
      // realign: one extra ones-edge would change state, so undo via fresh replay
      pinReset();
      for (int j = 0; j <= i; j++) begin
        tms = VEC[j][4];
        @(posedge tck);
        #1;
      end
    end

    // R3: five ones from every state along the table
    for (int k = 0; k < NV; k++) begin
      pinReset();
      for (int j = 0; j <= k; j++) tick(VEC[j][4]);
      for (int j = 0; j < 5; j++) tick(1'b1);
      check(tapState == 4'd0, $sformatf("R3 recover after prefix %0d", k), tapState, 0);
    end

    // R4: instruction load sequence; R3: four ones not yet in reset
    pinReset();
    tick(1'b0); tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b0);
    check(tapState == 4'd11, "R4 reach instruction shift", tapState, 11);
    check(tdoEnable == 1'b0, "R8 enable lags rising edge", tdoEnable, 0);
    #5;
    check(tdoEnable == 1'b1, "R8 enable after falling edge", tdoEnable, 1);
    tick(1'b0);
    check(tapState == 4'd11 && shiftIr, "R5 shift holds on zero", tapState, 11);
    tick(1'b1); tick(1'b1);
    check(tapState == 4'd15 && updateIr, "R4 reach instruction update", tapState, 15);
    pinReset();
    tick(1'b0); tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b0);
    tick(1'b1); tick(1'b1); tick(1'b1); tick(1'b1);
    check(tapState == 4'd9, "R3 four ones not reset", tapState, 9);
    tick(1'b1);
    check(tapState == 4'd0, "R3 fifth one reaches reset", tapState, 0);

    // R1: asynchronous pin reset mid-cycle from a shift state
    tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b0);
    #5;
    check(tapState == 4'd4 && tdoEnable, "R1 precondition data shift", tapState, 4);
    trstN = 1'b0;
    #1;
    check(tapState == 4'd0, "R1 async state", tapState, 0);
    check(tdoEnable == 1'b0, "R1 async enable", tdoEnable, 0);
    tick(1'b0);
    tick(1'b0);
    check(tapState == 4'd0, "R1 held while low", tapState, 0);
    trstN = 1'b1;
    tick(1'b0);
    check(tapState == 4'd1, "R1 release to idle", tapState, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule